// File: doc/BRIEF.md
# Serial Receive Queue with Trigger Level and Idle Timeout

This block buffers bytes arriving from a serial receiver in a sixteen-entry circular queue. A bus read of the receive data register drains it. The block keeps an occupancy count and raises a "receive ready" flag in one of two cases. The first is when the count reaches a trigger level chosen by two bits of a control write. The second is when the count stays under that level and no new byte has arrived for a fixed number of character times. In the second case, software still picks up a short message that never reaches the threshold.

The receiver delivers a byte with a one-cycle valid strobe. The serial control byte supplies two levels: a receive enable and an interrupt enable. The bus side supplies three things: a pop strobe for the data register, a write strobe with data for the queue control byte, and reads of the count output. The interrupt request is the ready flag masked by the interrupt enable. The character time is a parameter in clock cycles.

Top module: `serial_rx_queue`

## Requirements
- R1: The queue holds up to DEPTH (16) bytes and returns them in arrival order. `rx_count` reports the occupancy, from 0 to 16.
- R2: A control write sets the trigger level from `ctl_wdata[7:6]`: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14. After reset the level is 1.
- R3: When an accepted byte brings the count to the trigger level or above, `rx_full` is 1 after that clock edge, and any running idle timeout is cancelled.
- R4: When an accepted byte leaves the count below the trigger level, the idle timeout restarts. The timeout lasts TIMEOUT_CHARS*CHAR_CYCLES clocks (default 15*8 = 120). If no byte arrives in that window, `rx_full` rises exactly 120 edges after the accepting edge.
- R5: A pop (`rd_pop`) with a nonzero count removes the front byte. If the count after the pop is below the trigger level and nothing sets the flag in the same cycle, `rx_full` clears.
- R6: A byte arriving while the queue holds 16 entries is discarded. It leaves the count and the contents unchanged.
- R7: A control write with `ctl_wdata[1]`=1 empties the queue, clears `rx_full` and cancels the timeout. In that cycle it overrides any push or pop.
- R8: Bytes are accepted only while `ser_ctl[4]` (receive enable) is 1.
- R9: `rx_irq` is 1 exactly when `rx_full` is 1 and `ser_ctl[6]` (interrupt enable) is 1.
- R10: When the queue is empty, `rd_data` reads 0, and a pop changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_valid | input | 1 | One-cycle strobe: receiver has a byte |
| rx_byte | input | DW | Received byte |
| ser_ctl | input | 8 | Serial control byte: bit 4 receive enable, bit 6 interrupt enable |
| ctl_wr | input | 1 | Write strobe of the queue control byte |
| ctl_wdata | input | 8 | Queue control byte: bits 7:6 trigger select, bit 1 flush |
| rd_pop | input | 1 | Read strobe of the receive data register |
| rd_data | output | DW | Front byte, 0 when empty |
| rx_count | output | CW | Occupancy count |
| rx_full | output | 1 | Receive ready flag |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The assertions check the following on every cycle:
- the count never exceeds sixteen;
- a full queue does not grow;
- a flush leaves it empty with the flag low;
- the count does not move while reception is disabled and nothing is popped;
- a pop on a non-empty queue lowers the count by exactly one;
- the empty queue presents zero;
- the interrupt stays low while its enable is off.

Several behaviours depend on history that a simple property cannot follow, so only the bench scenarios show them:
- arrival-order data;
- the exact cycle of the timeout and its restart by a later byte;
- the flag rising at each of the four trigger levels;
- the flag clearing once pops drop the count under the level.

// File: rtl/srq_pkg.sv
package srq_pkg;

  typedef enum logic [1:0] {
    TRG_ONE      = 2'd0,
    TRG_FOUR     = 2'd1,
    TRG_EIGHT    = 2'd2,
    TRG_FOURTEEN = 2'd3
  } trig_sel_e;

  // queue control byte fields
  localparam int unsigned CTL_TRIG_LSB = 6;
  localparam int unsigned CTL_FLUSH    = 1;
  // serial control byte fields
  localparam int unsigned SCTL_RX_EN   = 4;
  localparam int unsigned SCTL_IRQ_EN  = 6;

  function automatic int unsigned trig_level(trig_sel_e sel);
    case (sel)
      TRG_ONE:   return 1;
      TRG_FOUR:  return 4;
      TRG_EIGHT: return 8;
      default:   return 14;
    endcase
  endfunction

endpackage

// File: rtl/srq_rst_sync.sv
module srq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/srq_store.sv
module srq_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  input  logic [DW-1:0] wr_byte,
  output logic [DW-1:0] front,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nxt
);

  localparam int AW = $clog2(DEPTH);

  logic [DEPTH-1:0][DW-1:0] mem_q;
  logic [DEPTH-1:0]         wen;
  logic [AW-1:0]            wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]            rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]            cnt_q, cnt_d;

  function automatic logic [AW-1:0] ptr_inc(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // per-entry write enables
  for (genvar g = 0; g < DEPTH; g++) begin : g_wen
    assign wen[g] = push && (wr_ptr_q == AW'(g));
  end

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push) wr_ptr_d = ptr_inc(wr_ptr_q);
      if (pop)  rd_ptr_d = ptr_inc(rd_ptr_q);
      case ({push, pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // storage: no reset, written only through its enable
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wen[i]) mem_q[i] <= wr_byte;
    end
  end

  assign front     = (cnt_q != '0) ? mem_q[rd_ptr_q] : '0;
  assign count     = cnt_q;
  assign count_nxt = cnt_d;

endmodule

// File: rtl/srq_timer.sv
module srq_timer #(
  parameter int TICKS = 120,
  parameter int TW    = $clog2(TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic cancel,
  output logic expire
);

  logic          armed_q, armed_d;
  logic [TW-1:0] cnt_q, cnt_d;

  assign expire = armed_q && (cnt_q == '0);

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (cancel) begin
      armed_d = 1'b0;
    end else if (restart) begin
      armed_d = 1'b1;
      cnt_d   = TW'(TICKS - 1);
    end else if (armed_q) begin
      if (cnt_q == '0) armed_d = 1'b0;
      else             cnt_d   = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/srq_level.sv
module srq_level
  import srq_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_wr,
  input  logic [1:0]    sel_in,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [CW-1:0] count_nxt,
  input  logic          expire,
  output logic          full,
  output logic          hit
);

  trig_sel_e     sel_q, sel_d;
  logic [CW-1:0] trig;
  logic          full_q, full_d;
  logic          drop;

  assign trig = CW'(trig_level(sel_q));
  assign hit  = push && (count_nxt >= trig);
  assign drop = pop && (count_nxt < trig);

  always_comb begin
    sel_d = sel_wr ? trig_sel_e'(sel_in) : sel_q;
    if (flush)               full_d = 1'b0;
    else if (hit || expire)  full_d = 1'b1;
    else if (drop)           full_d = 1'b0;
    else                     full_d = full_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= TRG_ONE;
      full_q <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      full_q <= full_d;
    end
  end

  assign full = full_q;

endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
  import srq_pkg::*;
#(
  parameter int  DW            = 8,
  parameter int  DEPTH         = 16,
  parameter int  CHAR_CYCLES   = 8,
  parameter int  TIMEOUT_CHARS = 15,
  parameter int  RST_STAGES    = 2,
  localparam int CW            = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic [7:0]    ser_ctl,
  input  logic          ctl_wr,
  input  logic [7:0]    ctl_wdata,
  input  logic          rd_pop,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] rx_count,
  output logic          rx_full,
  output logic          rx_irq
);

  localparam int TICKS = CHAR_CYCLES * TIMEOUT_CHARS;

  logic          rst_int_n;
  logic          flush, push_ok, pop_ok;
  logic          expire, hit;
  logic [CW-1:0] count_nxt;
  logic          unused_ctl_bits;

  assign unused_ctl_bits = ^{ctl_wdata[5:2], ctl_wdata[0], ser_ctl[7], ser_ctl[5], ser_ctl[3:0]};

  srq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_int_n)
  );

  assign flush   = ctl_wr && ctl_wdata[CTL_FLUSH];
  assign push_ok = rx_valid && ser_ctl[SCTL_RX_EN] && (rx_count != CW'(DEPTH)) && !flush;
  assign pop_ok  = rd_pop && (rx_count != '0) && !flush;

  srq_store #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_store (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .push      (push_ok),
    .pop       (pop_ok),
    .flush     (flush),
    .wr_byte   (rx_byte),
    .front     (rd_data),
    .count     (rx_count),
    .count_nxt (count_nxt)
  );

  srq_timer #(.TICKS(TICKS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .restart (push_ok && !hit),
    .cancel  (flush || hit),
    .expire  (expire)
  );

  srq_level #(.CW(CW)) u_level (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sel_wr    (ctl_wr),
    .sel_in    (ctl_wdata[CTL_TRIG_LSB+1:CTL_TRIG_LSB]),
    .flush     (flush),
    .push      (push_ok),
    .pop       (pop_ok),
    .count_nxt (count_nxt),
    .expire    (expire),
    .full      (rx_full),
    .hit       (hit)
  );

  assign rx_irq = rx_full && ser_ctl[SCTL_IRQ_EN];

endmodule

// File: rtl/srq_checker.sv
module srq_checker #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          rx_en,
  input logic          irq_en,
  input logic          rd_pop,
  input logic          flush_req,
  input logic [DW-1:0] rd_data,
  input logic [CW-1:0] rx_count,
  input logic          rx_full,
  input logic          rx_irq
);

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(DEPTH)); // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == CW'(DEPTH) && !rd_pop && !flush_req) |=> rx_count == CW'(DEPTH)); // R6

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> (rx_count == '0 && !rx_full)); // R7

  AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !rd_pop && !flush_req) |=> $stable(rx_count)); // R8

  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && !rx_valid && !flush_req && rx_count != '0) |=> rx_count == $past(rx_count) - 1'b1); // R5

  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !rx_irq); // R9

  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count == '0 |-> rd_data == '0); // R10

endmodule

bind serial_rx_queue srq_checker #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_valid  (rx_valid),
  .rx_en     (ser_ctl[4]),
  .irq_en    (ser_ctl[6]),
  .rd_pop    (rd_pop),
  .flush_req (ctl_wr && ctl_wdata[1]),
  .rd_data   (rd_data),
  .rx_count  (rx_count),
  .rx_full   (rx_full),
  .rx_irq    (rx_irq)
);

// File: tb/tb_serial_rx_queue.sv
`timescale 1ns/1ps
module tb_serial_rx_queue;

  localparam int TICKS = 8 * 15;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic [7:0] ser_ctl = 8'h50;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic       rd_pop = 1'b0;
  logic [7:0] rd_data;
  logic [4:0] rx_count;
  logic       rx_full;
  logic       rx_irq;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  serial_rx_queue dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .ser_ctl(ser_ctl), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .rd_pop(rd_pop),
    .rd_data(rd_data), .rx_count(rx_count), .rx_full(rx_full), .rx_irq(rx_irq)
  );

  // ---------------- reference model ----------------
  logic [7:0] q[$];
  int  m_trig  = 1;
  bit  m_full  = 1'b0;
  bit  m_armed = 1'b0;
  int  m_tmr   = 0;

  function automatic int lvl(logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_trig = 1; m_full = 0; m_armed = 0; m_tmr = 0;
    end else begin
      bit fl, pk, pp, ex, ht;
      int ns;
      fl = ctl_wr && ctl_wdata[1];
      pp = rd_pop && (q.size() > 0) && !fl;
      pk = rx_valid && ser_ctl[4] && (q.size() < 16) && !fl;
      ex = m_armed && (m_tmr == 0);
      ns = q.size() + int'(pk) - int'(pp);
      ht = pk && (ns >= m_trig);
      if (fl || ht) m_armed = 0;
      else if (pk) begin m_armed = 1; m_tmr = TICKS - 1; end
      else if (m_armed) begin
        if (m_tmr == 0) m_armed = 0; else m_tmr--;
      end
      if (fl) m_full = 0;
      else if (ht || ex) m_full = 1;
      else if (pp && ns < m_trig) m_full = 0;
      if (fl) q.delete();
      else begin
        if (pp) void'(q.pop_front());
        if (pk) q.push_back(rx_byte);
      end
      if (ctl_wr) m_trig = lvl(ctl_wdata[7:6]);
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    chk("R1 count vs model", rx_count, q.size());
    chk("R1/R10 front byte vs model", rd_data, (q.size() > 0) ? q[0] : 0);
    chk("R3/R4/R5 ready flag vs model", rx_full, m_full);
    chk("R9 irq vs model", rx_irq, m_full && ser_ctl[6]);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cmp_model();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic push(logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b;
    tick();
    rx_valid = 1'b0;
  endtask

  task automatic pop();
    rd_pop = 1'b1;
    tick();
    rd_pop = 1'b0;
  endtask

  task automatic ctl(logic [7:0] w);
    ctl_wr = 1'b1; ctl_wdata = w;
    tick();
    ctl_wr = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // reset state
    chk("R1 reset count", rx_count, 0);
    chk("R3 reset flag", rx_full, 0);
    chk("R9 reset irq", rx_irq, 0);
    chk("R10 reset data", rd_data, 0);

    // default trigger level 1
    push(8'hA5);
    chk("R2 default level 1 sets flag", rx_full, 1);
    chk("R9 irq follows flag", rx_irq, 1);
    chk("R1 data out", rd_data, 8'hA5);
    pop();
    chk("R5 flag cleared after pop", rx_full, 0);
    chk("R10 empty reads zero", rd_data, 0);
    pop();
    chk("R10 pop on empty keeps count", rx_count, 0);

    // trigger 4, timeout and its restart
    ctl(8'h40);
    push(8'h11);
    idle(50);
    push(8'h22);
    push(8'h33);
    idle(TICKS - 1);
    chk("R4 flag low before timeout", rx_full, 0);
    idle(1);
    chk("R4 flag set by timeout", rx_full, 1);
    push(8'h44);
    chk("R3 level 4 reached", rx_count, 4);
    pop();
    chk("R5 flag clears under level", rx_full, 0);
    chk("R1 order second", rd_data, 8'h22);
    idle(TICKS + 5);
    chk("R3 timeout cancelled by hit", rx_full, 0);
    ctl(8'h02);

    // trigger 8 with interrupt masked
    ser_ctl = 8'h10;
    ctl(8'h80);
    for (int i = 0; i < 7; i++) push(8'(i + 8'h30));
    chk("R2 level 8 not yet", rx_full, 0);
    push(8'h37);
    chk("R2 level 8 reached", rx_full, 1);
    chk("R9 irq masked", rx_irq, 0);
    ser_ctl = 8'h50;
    tick();
    chk("R9 irq unmasked", rx_irq, 1);
    ctl(8'h82);
    chk("R7 flush empties", rx_count, 0);
    chk("R7 flush clears flag", rx_full, 0);

    // trigger 14 and overflow
    ctl(8'hC0);
    for (int i = 0; i < 13; i++) push(8'(i));
    chk("R2 level 14 not yet", rx_full, 0);
    push(8'd13);
    chk("R2 level 14 reached", rx_full, 1);
    push(8'd14);
    push(8'd15);
    for (int i = 0; i < 3; i++) push(8'hEE);
    chk("R6 full queue drops bytes", rx_count, 16);
    for (int i = 0; i < 16; i++) begin
      chk("R1 arrival order", rd_data, i);
      pop();
    end
    chk("R1 drained", rx_count, 0);

    // receive disabled
    ser_ctl = 8'h40;
    for (int i = 0; i < 3; i++) push(8'h99);
    chk("R8 disabled receiver ignores bytes", rx_count, 0);
    ser_ctl = 8'h50;

    // flush overrides push and pop
    push(8'h01);
    push(8'h02);
    rx_valid = 1'b1; rx_byte = 8'h03; rd_pop = 1'b1;
    ctl(8'h02);
    rx_valid = 1'b0; rd_pop = 1'b0;
    chk("R7 flush wins over push/pop", rx_count, 0);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      rx_valid  = ($urandom_range(0, 2) != 0);
      rx_byte   = 8'($urandom);
      rd_pop    = ($urandom_range(0, 3) == 0);
      ctl_wr    = ($urandom_range(0, 199) == 0);
      ctl_wdata = {2'($urandom), 4'h0, ($urandom_range(0, 3) == 0), 1'b0};
      ser_ctl   = {1'b0, ($urandom_range(0, 3) != 0), 1'b0, ($urandom_range(0, 9) != 0), 4'h0};
      if (i % 500 > 300) rx_valid = 1'b0;
      tick();
    end
    rx_valid = 1'b0; rd_pop = 1'b0; ctl_wr = 1'b0;
    idle(TICKS + 4);

    summary();
    $finish;
  end

endmodule